// File: doc/BRIEF.md
# Coprocessor Operand Block Mover

This sequencer carries one group of equal-length operands between a coprocessor's operand register port and memory on behalf of a single transfer primitive. A one-cycle start pulse captures the direction, the addressing mode, an 8-bit register select mask and the operand length in bytes. It also captures the current address register value. The number of set bits in the mask gives the number of operands. The block then steps through every operand. Each operand is cut into ascending chunks: 32-bit long words first, then at most one 16-bit word and one byte for the remainder. Each chunk passes once through memory and once through the operand port.

When memory is the source, a chunk is read from memory and then offered to the coprocessor. When the coprocessor is the source, a chunk is accepted from the port and then written to memory. In control mode the operands sit back to back upward from the effective address. Postincrement uses the same layout and also advances the address register. Predecrement places operand 0 in the highest block and each later operand one block below. Bytes inside an operand still rise in address. After the last chunk a one-cycle done pulse marks the point where the updated address register value is valid.

Top module: `cpx_mover`

## Requirements
- R1: A start pulse is taken only while the block is idle. It latches all request inputs, and a start pulse during a running transfer changes neither the access sequence nor the final register value. While idle, no memory request, port valid or port ready is raised, and after reset done_o=0 and areg_o=0.
- R2: With dir_i=0, each chunk is first read from memory (mem_we_o=0) and then offered on cp_out_data_o. The offered data is the read data with only the chunk's low bytes kept and zeros above.
- R3: With dir_i=1, each chunk is first accepted from cp_in_data_i and then written to memory (mem_we_o=1). mem_wdata_o carries the accepted data with only the chunk's low bytes kept and zeros above.
- R4: The operand count is the popcount of mask_i. A zero mask or a zero length produces no memory or port traffic, and done_o rises in the cycle after the start edge with areg_o equal to areg_i.
- R5: Each operand is moved as chunks at rising offsets: long words while at least 4 bytes remain, then a 16-bit word if at least 2 remain, then a byte. The size code is 0 for byte, 1 for word and 2 for long on both mem_size_o and cp_size_o.
- R6: In control mode (mode_i=0, and also code 3), operand k starts at ea+k*L and areg_o ends equal to ea.
- R7: In postincrement mode (mode_i=1), operand k starts at ea+k*L and areg_o ends at ea+N*L.
- R8: In predecrement mode (mode_i=2), operand k starts at ea-(k+1)*L, with its bytes still at ascending addresses, and areg_o ends at ea-N*L.
- R9: mem_req_o stays high with a stable address, size and write flag until mem_ack_i is sampled high, and no access occurs that the sequence does not call for.
- R10: cp_out_valid_o holds its data stable until cp_out_ready_i. cp_in_ready_o is raised only while a chunk is awaited. Memory and port are never engaged in the same cycle.
- R11: done_o is a one-cycle pulse that follows completion of the final chunk. From that cycle until the next start, areg_o holds the updated register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse for one primitive |
| dir_i | input | 1 | 0: memory to port, 1: port to memory |
| mode_i | input | 2 | 0 control, 1 postincrement, 2 predecrement |
| mask_i | input | MASK_W | Register select mask; popcount gives operand count |
| oplen_i | input | LEN_W | Operand length in bytes |
| areg_i | input | ADDR_W | Effective address / initial register value |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory access is a write |
| mem_addr_o | output | ADDR_W | Byte address of the chunk |
| mem_size_o | output | 2 | Chunk size code |
| mem_wdata_o | output | 32 | Write data, low bytes significant |
| mem_ack_i | input | 1 | Memory acknowledge |
| mem_rdata_i | input | 32 | Read data, low bytes significant |
| cp_out_valid_o | output | 1 | Chunk offered to coprocessor |
| cp_out_data_o | output | 32 | Offered chunk data |
| cp_size_o | output | 2 | Size code of the chunk at the port |
| cp_out_ready_i | input | 1 | Coprocessor accepts offered chunk |
| cp_in_ready_o | output | 1 | Block awaits a chunk from coprocessor |
| cp_in_valid_i | input | 1 | Coprocessor chunk valid |
| cp_in_data_i | input | 32 | Coprocessor chunk data |
| done_o | output | 1 | One-cycle completion pulse |
| areg_o | output | ADDR_W | Updated address register value |

## Verification
The assertions assume that the memory holds mem_ack_i low while no request is pending, and that the coprocessor needs no particular ready or valid timing, since the block waits on both indefinitely. They also assume the operand length is at least the width that makes the 4-byte comparison meaningful. The stimulus drives acknowledge only in answer to a visible request and chooses ready and valid at random each cycle. It also injects a stray start while a transfer is in flight, and it keeps the lengths within the range of the length port.

// File: rtl/cpx_pkg.sv
package cpx_pkg;

  localparam int unsigned WORD_BITS = 32;

  typedef enum logic [1:0] {
    XS_BYTE = 2'd0,
    XS_HALF = 2'd1,
    XS_LONG = 2'd2
  } xsize_e;

  typedef enum logic [1:0] {
    AM_CTRL = 2'd0,
    AM_INC  = 2'd1,
    AM_DEC  = 2'd2
  } amode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MRD,
    ST_POUT,
    ST_PIN,
    ST_MWR,
    ST_FIN
  } st_e;

  // byte count carried by one chunk of the given size
  function automatic logic [2:0] xsize_bytes(xsize_e s);
    case (s)
      XS_LONG: return 3'd4;
      XS_HALF: return 3'd2;
      default: return 3'd1;
    endcase
  endfunction

  // keep the low bytes that belong to a chunk, clear the rest
  function automatic logic [WORD_BITS-1:0] lane_keep(logic [WORD_BITS-1:0] d, xsize_e s);
    case (s)
      XS_LONG: return d;
      XS_HALF: return {{(WORD_BITS-16){1'b0}}, d[15:0]};
      default: return {{(WORD_BITS-8){1'b0}}, d[7:0]};
    endcase
  endfunction

endpackage

// File: rtl/cpx_walk.sv
module cpx_walk
  import cpx_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] op_o,
  output logic [LEN_W-1:0] off_o,
  output logic [LEN_W-1:0] rem_o,
  output xsize_e           size_o,
  output logic             last_op_o,
  output logic             last_all_o
);

  logic [CNT_W-1:0] op_q;
  logic [LEN_W-1:0] off_q;
  logic [LEN_W-1:0] rem;
  xsize_e           size;
  logic [2:0]       nbytes;
  logic             last_op;

  always_comb begin
    rem = len_i - off_q;
    if (rem >= LEN_W'(4))      size = XS_LONG;
    else if (rem >= LEN_W'(2)) size = XS_HALF;
    else                       size = XS_BYTE;
    nbytes  = xsize_bytes(size);
    last_op = (rem == LEN_W'(nbytes));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q  <= '0;
      off_q <= '0;
    end else if (load_i) begin
      op_q  <= '0;
      off_q <= '0;
    end else if (step_i) begin
      if (last_op) begin
        op_q  <= op_q + CNT_W'(1);
        off_q <= '0;
      end else begin
        off_q <= off_q + LEN_W'(nbytes);
      end
    end
  end

  assign op_o       = op_q;
  assign off_o      = off_q;
  assign rem_o      = rem;
  assign size_o     = size;
  assign last_op_o  = last_op;
  assign last_all_o = last_op && (op_q == cnt_i - CNT_W'(1));

endmodule

// File: rtl/cpx_addr.sv
module cpx_addr
  import cpx_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8,
  parameter int CNT_W  = 4
) (
  input  amode_e            mode_i,
  input  logic [ADDR_W-1:0] ea_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CNT_W-1:0]  op_i,
  input  logic [LEN_W-1:0]  off_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ADDR_W-1:0] final_o
);

  // lowest address of operand k
  function automatic logic [ADDR_W-1:0] blk_base(amode_e m, logic [ADDR_W-1:0] ea,
                                                 logic [CNT_W-1:0] k, logic [LEN_W-1:0] l);
    logic [ADDR_W-1:0] kx, lx;
    kx = ADDR_W'(k);
    lx = ADDR_W'(l);
    if (m == AM_DEC) return ea - (kx + ADDR_W'(1)) * lx;
    else             return ea + kx * lx;
  endfunction

  // register value once all operands have moved
  function automatic logic [ADDR_W-1:0] end_value(amode_e m, logic [ADDR_W-1:0] ea,
                                                  logic [CNT_W-1:0] n, logic [LEN_W-1:0] l);
    logic [ADDR_W-1:0] span;
    span = ADDR_W'(n) * ADDR_W'(l);
    case (m)
      AM_INC:  return ea + span;
      AM_DEC:  return ea - span;
      default: return ea;
    endcase
  endfunction

  assign addr_o  = blk_base(mode_i, ea_i, op_i, len_i) + ADDR_W'(off_i);
  assign final_o = end_value(mode_i, ea_i, cnt_i, len_i);

endmodule

// File: rtl/cpx_mover.sv
module cpx_mover
  import cpx_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8,
  parameter int MASK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              dir_i,
  input  logic [1:0]        mode_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic [LEN_W-1:0]  oplen_i,
  input  logic [ADDR_W-1:0] areg_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [1:0]        mem_size_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              cp_out_valid_o,
  output logic [31:0]       cp_out_data_o,
  output logic [1:0]        cp_size_o,
  input  logic              cp_out_ready_i,
  output logic              cp_in_ready_o,
  input  logic              cp_in_valid_i,
  input  logic [31:0]       cp_in_data_i,
  output logic              done_o,
  output logic [ADDR_W-1:0] areg_o
);

  localparam int CNT_W  = $clog2(MASK_W + 1);
  localparam int DATA_W = WORD_BITS;

  function automatic logic [CNT_W-1:0] popcnt(logic [MASK_W-1:0] m);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int i = 0; i < MASK_W; i++) c = c + CNT_W'(m[i]);
    return c;
  endfunction

  st_e               st_q, st_d;
  logic              dir_q;
  amode_e            mode_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [LEN_W-1:0]  len_q;
  logic [ADDR_W-1:0] ea_q;
  logic [DATA_W-1:0] data_q;
  logic [ADDR_W-1:0] areg_q;

  logic [CNT_W-1:0]  wk_op;
  logic [LEN_W-1:0]  wk_off;
  logic [LEN_W-1:0]  wk_rem;
  xsize_e            wk_size;
  logic              wk_last_op;
  logic              wk_last_all;
  logic [ADDR_W-1:0] ag_addr;
  logic [ADDR_W-1:0] ag_final;

  // named internal events, also used by the checker
  logic              ev_accept;
  logic              ev_empty;
  logic              ev_step;
  logic              ev_finish;
  logic              ev_busy;
  logic [CNT_W-1:0]  start_cnt;

  assign start_cnt = popcnt(mask_i);
  assign ev_accept = (st_q == ST_IDLE) && start_i;
  assign ev_empty  = (start_cnt == '0) || (oplen_i == '0);
  assign ev_step   = ((st_q == ST_POUT) && cp_out_ready_i) ||
                     ((st_q == ST_MWR)  && mem_ack_i);
  assign ev_busy   = (st_q != ST_IDLE);
  assign ev_finish = (st_d == ST_FIN) && (st_q != ST_FIN);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (start_i) st_d = ev_empty ? ST_FIN : (dir_i ? ST_PIN : ST_MRD);
      ST_MRD:  if (mem_ack_i) st_d = ST_POUT;
      ST_POUT: if (cp_out_ready_i) st_d = wk_last_all ? ST_FIN : ST_MRD;
      ST_PIN:  if (cp_in_valid_i) st_d = ST_MWR;
      ST_MWR:  if (mem_ack_i) st_d = wk_last_all ? ST_FIN : ST_PIN;
      ST_FIN:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      dir_q  <= 1'b0;
      mode_q <= AM_CTRL;
      cnt_q  <= '0;
      len_q  <= '0;
      ea_q   <= '0;
      data_q <= '0;
      areg_q <= '0;
    end else begin
      st_q <= st_d;
      if (ev_accept) begin
        dir_q  <= dir_i;
        mode_q <= (mode_i == 2'd3) ? AM_CTRL : amode_e'(mode_i);
        cnt_q  <= start_cnt;
        len_q  <= oplen_i;
        ea_q   <= areg_i;
        if (ev_empty) areg_q <= areg_i;
      end
      if ((st_q == ST_MRD) && mem_ack_i) data_q <= lane_keep(mem_rdata_i, wk_size);
      if ((st_q == ST_PIN) && cp_in_valid_i) data_q <= lane_keep(cp_in_data_i, wk_size);
      if (ev_step && wk_last_all) areg_q <= ag_final;
    end
  end

  cpx_walk #(
    .LEN_W (LEN_W),
    .CNT_W (CNT_W)
  ) u_walk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (ev_accept),
    .step_i     (ev_step),
    .len_i      (len_q),
    .cnt_i      (cnt_q),
    .op_o       (wk_op),
    .off_o      (wk_off),
    .rem_o      (wk_rem),
    .size_o     (wk_size),
    .last_op_o  (wk_last_op),
    .last_all_o (wk_last_all)
  );

  cpx_addr #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W),
    .CNT_W  (CNT_W)
  ) u_addr (
    .mode_i  (mode_q),
    .ea_i    (ea_q),
    .len_i   (len_q),
    .cnt_i   (cnt_q),
    .op_i    (wk_op),
    .off_i   (wk_off),
    .addr_o  (ag_addr),
    .final_o (ag_final)
  );

  assign mem_req_o      = (st_q == ST_MRD) || (st_q == ST_MWR);
  assign mem_we_o       = dir_q;
  assign mem_addr_o     = ag_addr;
  assign mem_size_o     = wk_size;
  assign mem_wdata_o    = data_q;
  assign cp_out_valid_o = (st_q == ST_POUT);
  assign cp_out_data_o  = data_q;
  assign cp_size_o      = wk_size;
  assign cp_in_ready_o  = (st_q == ST_PIN);
  assign done_o         = (st_q == ST_FIN);
  assign areg_o         = areg_q;

endmodule

// File: rtl/cpx_mover_chk.sv
module cpx_mover_chk #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req_o,
  input logic              mem_ack_i,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [1:0]        mem_size_o,
  input logic              cp_out_valid_o,
  input logic              cp_out_ready_i,
  input logic [31:0]       cp_out_data_o,
  input logic              cp_in_ready_o,
  input logic              done_o,
  input logic              ev_finish,
  input logic              ev_busy,
  input logic [LEN_W-1:0]  rem_i
);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) &&
                                $stable(mem_size_o) && $stable(mem_we_o)); // R9

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cp_out_valid_o && !cp_out_ready_i |=> cp_out_valid_o && $stable(cp_out_data_o)); // R10

  AST_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req_o && (cp_out_valid_o || cp_in_ready_o))); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_busy |-> !mem_req_o && !cp_out_valid_o && !cp_in_ready_o); // R1

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R11

  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(ev_finish)); // R11

  AST_LONG_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && (mem_size_o != 2'd2) |-> rem_i < LEN_W'(4)); // R5

endmodule

bind cpx_mover cpx_mover_chk #(
  .ADDR_W (ADDR_W),
  .LEN_W  (LEN_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .mem_req_o      (mem_req_o),
  .mem_ack_i      (mem_ack_i),
  .mem_we_o       (mem_we_o),
  .mem_addr_o     (mem_addr_o),
  .mem_size_o     (mem_size_o),
  .cp_out_valid_o (cp_out_valid_o),
  .cp_out_ready_i (cp_out_ready_i),
  .cp_out_data_o  (cp_out_data_o),
  .cp_in_ready_o  (cp_in_ready_o),
  .done_o         (done_o),
  .ev_finish      (ev_finish),
  .ev_busy        (ev_busy),
  .rem_i          (wk_rem)
);

// File: tb/test_cpx_mover.sv
module test_cpx_mover;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        dir_i = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic [7:0]  mask_i = 8'd0;
  logic [7:0]  oplen_i = 8'd0;
  logic [31:0] areg_i = 32'd0;
  logic        mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o;
  logic [1:0]  mem_size_o;
  logic [31:0] mem_wdata_o;
  logic        mem_ack_i = 1'b0;
  logic [31:0] mem_rdata_i = 32'd0;
  logic        cp_out_valid_o;
  logic [31:0] cp_out_data_o;
  logic [1:0]  cp_size_o;
  logic        cp_out_ready_i = 1'b0;
  logic        cp_in_ready_o;
  logic        cp_in_valid_i = 1'b0;
  logic [31:0] cp_in_data_i = 32'd0;
  logic        done_o;
  logic [31:0] areg_o;

  cpx_mover i_cpx_mover (.*);

  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int done_cnt = 0;

  // reference model state
  logic [31:0] q_addr[$];
  int          q_size[$];
  logic [31:0] q_tok[$];
  logic [31:0] q_port[$];
  int          q_psize[$];
  logic [31:0] tok = 32'h1000_0001;
  logic        cur_dir = 1'b0;
  int          cur_mode = 0;
  logic [31:0] exp_final = 32'd0;

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string mode_req(int m);
    if (m == 1) return "R7";
    if (m == 2) return "R8";
    return "R6";
  endfunction

  function automatic logic [31:0] mem_word(logic [31:0] a);
    return {~a[15:0], a[15:0]};
  endfunction

  function automatic logic [31:0] keep(logic [31:0] d, int nb);
    if (nb == 4) return d;
    if (nb == 2) return d & 32'h0000_ffff;
    return d & 32'h0000_00ff;
  endfunction

  function automatic int code_bytes(logic [1:0] c);
    if (c == 2'd2) return 4;
    if (c == 2'd1) return 2;
    return 1;
  endfunction

  // bus and port responders, compared every clock
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req_o) begin
        bit ack;
        ack = ($urandom % 3) != 0;
        mem_ack_i = ack;
        mem_rdata_i = mem_word(mem_addr_o);
        if (q_addr.size() == 0) begin
          chk(0, "R9", "access with none due", mem_addr_o, 32'd0);
          mem_ack_i = 1'b1;
        end else if (ack) begin
          logic [31:0] ea;
          int sz;
          ea = q_addr.pop_front();
          sz = q_size.pop_front();
          chk(mem_addr_o == ea, mode_req(cur_mode), "address", mem_addr_o, ea);
          chk(code_bytes(mem_size_o) == sz, "R5", "mem size", 32'(code_bytes(mem_size_o)), 32'(sz));
          chk(mem_we_o == cur_dir, cur_dir ? "R3" : "R2", "write flag", 32'(mem_we_o), 32'(cur_dir));
          if (cur_dir) begin
            logic [31:0] t;
            t = (q_tok.size() != 0) ? q_tok.pop_front() : 32'hdead_beef;
            chk(mem_wdata_o == keep(t, sz), "R3", "write data", mem_wdata_o, keep(t, sz));
          end else begin
            q_port.push_back(keep(mem_word(ea), sz));
            q_psize.push_back(sz);
          end
        end
      end else begin
        mem_ack_i = 1'b0;
      end

      if (cp_out_valid_o) begin
        bit rdy;
        rdy = ($urandom % 2) == 0;
        cp_out_ready_i = rdy;
        if (rdy) begin
          if (q_port.size() == 0) chk(0, "R2", "port offer with none due", cp_out_data_o, 32'd0);
          else begin
            logic [31:0] e;
            int s;
            e = q_port.pop_front();
            s = q_psize.pop_front();
            chk(cp_out_data_o == e, "R2", "port data", cp_out_data_o, e);
            chk(code_bytes(cp_size_o) == s, "R5", "port size", 32'(code_bytes(cp_size_o)), 32'(s));
          end
        end
      end else begin
        cp_out_ready_i = 1'b0;
      end

      begin
        bit v;
        v = ($urandom % 3) != 0;
        cp_in_valid_i = v;
        cp_in_data_i = tok;
        if (v && cp_in_ready_o) begin
          q_tok.push_back(tok);
          tok = tok * 32'd5 + 32'h0103_0507;
        end
      end

      if (done_o) begin
        done_cnt++;
        chk(q_addr.size() == 0, "R11", "done before last chunk", 32'(q_addr.size()), 32'd0);
        chk(areg_o == exp_final, mode_req(cur_mode), "final register", areg_o, exp_final);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic run(bit d, int m, logic [7:0] mk, int len, logic [31:0] ea, bit poke);
    int n;
    bit empty;
    @(negedge clk);
    n = 0;
    for (int i = 0; i < 8; i++) if (mk[i]) n++;
    empty = (n == 0) || (len == 0);
    if (!empty) begin
      for (int k = 0; k < n; k++) begin
        logic [31:0] base;
        int off;
        base = (m == 2) ? ea - 32'((k + 1) * len) : ea + 32'(k * len);
        off = 0;
        while (off < len) begin
          int r, s;
          r = len - off;
          s = (r >= 4) ? 4 : ((r >= 2) ? 2 : 1);
          q_addr.push_back(base + 32'(off));
          q_size.push_back(s);
          off += s;
        end
      end
    end
    if (empty || m == 0 || m == 3) exp_final = ea;
    else if (m == 1) exp_final = ea + 32'(n * len);
    else exp_final = ea - 32'(n * len);
    cur_dir = d;
    cur_mode = (m == 3) ? 0 : m;
    q_tok.delete();
    done_cnt = 0;
    dir_i = d; mode_i = 2'(m); mask_i = mk; oplen_i = 8'(len); areg_i = ea;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (empty) chk(done_o == 1'b1, "R4", "empty request done timing", 32'(done_o), 32'd1);
    if (poke) begin
      repeat (3) @(negedge clk);
      dir_i = ~d; mode_i = 2'd1; mask_i = 8'hff; oplen_i = 8'd9; areg_i = 32'h7777_0000;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    for (int w = 0; w < 4000 && done_cnt == 0; w++) @(negedge clk);
    @(negedge clk);
    chk(done_cnt == 1, "R11", "done pulse count", 32'(done_cnt), 32'd1);
    chk(done_o == 1'b0, "R11", "done dropped", 32'(done_o), 32'd0);
    chk(areg_o == exp_final, "R11", "register held after done", areg_o, exp_final);
    if (poke) chk(areg_o == exp_final, "R1", "stray start ignored", areg_o, exp_final);
    if (empty) chk(q_port.size() == 0, "R4", "no traffic", 32'(q_port.size()), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done_o == 1'b0, "R1", "reset done", 32'(done_o), 32'd0);
    chk(areg_o == 32'd0, "R1", "reset register", areg_o, 32'd0);
    chk(!mem_req_o && !cp_out_valid_o && !cp_in_ready_o, "R1", "reset quiet",
        32'({mem_req_o, cp_out_valid_o, cp_in_ready_o}), 32'd0);

    run(1'b0, 2, 8'b0000_0011, 12, 32'h0000_1000, 1'b0);  // R8 two 12-byte operands
    run(1'b1, 2, 8'b1000_0001, 12, 32'h0000_2000, 1'b0);  // R8 R3
    run(1'b0, 0, 8'hf0, 7, 32'h0000_3000, 1'b0);          // R6 R5 odd length
    run(1'b1, 1, 8'h0f, 7, 32'h0000_4001, 1'b0);          // R7 R3
    run(1'b0, 1, 8'hff, 1, 32'h0000_5000, 1'b0);          // R7 byte only
    run(1'b1, 0, 8'h24, 3, 32'h0000_6000, 1'b0);          // R6 word+byte
    run(1'b1, 2, 8'h07, 5, 32'h0000_7000, 1'b0);          // R8 long+byte
    run(1'b0, 3, 8'h01, 6, 32'h0000_8000, 1'b0);          // R6 code 3
    run(1'b0, 2, 8'h00, 4, 32'h0000_9000, 1'b0);          // R4 zero mask
    run(1'b1, 1, 8'h11, 0, 32'h0000_a000, 1'b0);          // R4 zero length
    run(1'b0, 2, 8'h03, 10, 32'h0000_b000, 1'b1);         // R1 stray start
    run(1'b1, 1, 8'h05, 2, 32'h0000_c000, 1'b1);          // R1 R7

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule